// File: doc/BRIEF.md
# Per-Buffer Interrupt Flag Controller

This block keeps the interrupt enable bits and the pending-event bits for a communication controller with sixteen message buffers, and turns them into interrupt requests. Each buffer reports a finished transmission or reception with a one-cycle event pulse, and that pulse latches the buffer's pending bit. Software sees two 16-bit registers, selected by a one-bit address: the enable register (address 0) and the pending register (address 1). Either byte lane of either register can be written alone through a two-bit byte enable, or both lanes together.

Pending bits are cleared only by writing ones to them. Writing zeros leaves them alone, and so does any write to the enable register. The block drives a per-buffer vector of pending bits that are enabled, plus one request line. The request line is the registered OR of that vector, so it carries no glitches. When an enable bit changes while its pending bit is already set, the interrupt appears or disappears straight away. If a buffer event arrives in the same cycle that software clears that buffer's bit, the event wins, so no completion is lost.

Top module: `bufirq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable register and the pending register to 0, and after it both `irq_vec_o` and `irq_o` read 0.
- R2: An event pulse on `evt_i[n]` at a clock edge sets pending bit n, and the new value is visible from the next cycle on.
- R3: A write with `host_sel_i`=1 clears each pending bit whose write-data bit is 1 in an enabled lane. Pending bits whose write-data bit is 0 keep their value.
- R4: `host_be_i[0]` enables bits 7..0 and `host_be_i[1]` enables bits 15..8, for both registers. Bits in a lane whose enable is 0 do not change on a write.
- R5: A write with `host_sel_i`=0 stores the write data into the enable register for the enabled lanes.
- R6: `irq_vec_o[n]` equals pending bit n AND enable bit n, and it follows the registers in the same cycle they change.
- R7: Changing an enable bit while its pending bit is set asserts or negates `irq_vec_o[n]` with no new event.
- R8: When an event on buffer n and a write-one clear of pending bit n happen in the same cycle, pending bit n ends up 1.
- R9: `irq_o` is the OR of `irq_vec_o`, registered, so it follows one cycle after the vector.
- R10: A read strobe loads `host_rdata_o` on the next cycle with the selected register (0 = enable, 1 = pending). The value holds until the next read, and reading never changes the pending bits.
- R11: Writes to the enable register never change the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 16 | Per-buffer completion pulses |
| host_sel_i | input | 1 | Register select: 0 enable, 1 pending |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_be_i | input | 2 | Byte-lane enables, bit 0 = low byte |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Registered read data |
| irq_vec_o | output | 16 | Enabled pending bits per buffer |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Some rules are checked on every cycle by the assertions: an event always leaves its pending bit set, a pending bit only rises after an event, and it only falls after a write-one clear to the pending register in its lane. They also check that the enable register changes only on an enable write, that no interrupt appears without its enable bit, and that the request line rises only after the vector was non-zero. Other behaviours can only be shown by the bench scenarios, because they need specific values at the ports: byte-lane selection, the event winning over a clear in the same cycle, the interrupt following an enable change on a bit that is already pending, and reads that return data without side effects.

// File: rtl/bufirq_pkg.sv
package bufirq_pkg;
   typedef enum logic {
      SEL_MASK = 1'b0,
      SEL_FLAG = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/bufirq_lane_expand.sv
// Expands per-lane byte enables into a per-bit write enable.
module bufirq_lane_expand #(
   parameter int NUM_BUF = 16,
   parameter int LANE_W  = 8,
   localparam int NUM_LANES = NUM_BUF / LANE_W
) (
   input  logic                 wr_i,
   input  logic [NUM_LANES-1:0] be_i,
   output logic [NUM_BUF-1:0]   wen_o
);
   for (genvar b = 0; b < NUM_BUF; b++) begin : g_bit
      assign wen_o[b] = wr_i & be_i[b / LANE_W];
   end
endmodule

// File: rtl/bufirq_mask_reg.sv
module bufirq_mask_reg #(
   parameter int NUM_BUF = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_BUF-1:0] wen_i,
   input  logic [NUM_BUF-1:0] wdata_i,
   output logic [NUM_BUF-1:0] mask_o
);
   logic [NUM_BUF-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (rst) mask_q <= '0;
      else     mask_q <= (mask_q & ~wen_i) | (wdata_i & wen_i);
   end

   assign mask_o = mask_q;

   // R1: reset clears the enable register
   a_r1_mask_reset: assert property (@(posedge clk) rst |=> (mask_q == '0));
   // R4: bits with no write enable hold their value
   a_r4_mask_lane_hold: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(wen_i)) == '0));
endmodule

// File: rtl/bufirq_flag_reg.sv
module bufirq_flag_reg #(
   parameter int NUM_BUF = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_BUF-1:0] evt_i,
   input  logic [NUM_BUF-1:0] wen_i,
   input  logic               sel_flag_i,
   input  logic [NUM_BUF-1:0] wdata_i,
   output logic [NUM_BUF-1:0] flag_o
);
   logic [NUM_BUF-1:0] flag_q;
   logic [NUM_BUF-1:0] clr;

   // write-one-to-clear, limited to enabled lanes of a pending-register write
   assign clr = sel_flag_i ? (wdata_i & wen_i) : '0;

   // an event in the same cycle overrides a clear
   always_ff @(posedge clk) begin
      if (rst) flag_q <= '0;
      else     flag_q <= (flag_q & ~clr) | evt_i;
   end

   assign flag_o = flag_q;

   a_r1_flag_reset: assert property (@(posedge clk) rst |=> (flag_q == '0));
   // R2 / R8: every event leaves its bit set
   a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
      (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
   // R2: a bit rises only after an event
   a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0));
   // R3 / R11: a bit falls only after a write-one to the pending register
   a_r3_clear_only_w1c: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(flag_q) & ~flag_q &
                 ~({NUM_BUF{$past(sel_flag_i)}} & $past(wdata_i) & $past(wen_i))) == '0));
endmodule

// File: rtl/bufirq_irq_combine.sv
module bufirq_irq_combine #(
   parameter int NUM_BUF = 16,
   parameter bit REG_REQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_BUF-1:0] flag_i,
   input  logic [NUM_BUF-1:0] mask_i,
   output logic [NUM_BUF-1:0] vec_o,
   output logic               req_o
);
   assign vec_o = flag_i & mask_i;

   if (REG_REQ) begin : g_reg_req
      logic req_q;
      always_ff @(posedge clk) begin
         if (rst) req_q <= 1'b0;
         else     req_q <= |vec_o;
      end
      assign req_o = req_q;
      // R9: the request rises only after a non-zero vector
      a_r9_req_follows_vec: assert property (@(posedge clk) disable iff (rst)
         $rose(req_q) |-> $past(|vec_o));
   end else begin : g_comb_req
      assign req_o = |vec_o;
   end

   // R6: no interrupt without its enable bit
   a_r6_mask_gates: assert property (@(posedge clk) disable iff (rst)
      ((vec_o & ~mask_i) == '0));
endmodule

// File: rtl/bufirq_ctrl.sv
module bufirq_ctrl
   import bufirq_pkg::*;
#(
   parameter int NUM_BUF = 16,
   parameter int LANE_W  = 8,
   parameter bit REG_REQ = 1'b1,
   localparam int NUM_LANES = NUM_BUF / LANE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_BUF-1:0]   evt_i,
   input  logic                 host_sel_i,
   input  logic                 host_wr_i,
   input  logic                 host_rd_i,
   input  logic [NUM_LANES-1:0] host_be_i,
   input  logic [NUM_BUF-1:0]   host_wdata_i,
   output logic [NUM_BUF-1:0]   host_rdata_o,
   output logic [NUM_BUF-1:0]   irq_vec_o,
   output logic                 irq_o
);
   if (NUM_BUF < 1 || LANE_W < 1 || (NUM_BUF % LANE_W) != 0) begin : g_bad_cfg
      $error("bufirq_ctrl: NUM_BUF must be a positive multiple of LANE_W");
   end

   reg_sel_e           sel;
   logic [NUM_BUF-1:0] wen_mask, wen_flag;
   logic [NUM_BUF-1:0] mask_q, flag_q;
   logic [NUM_BUF-1:0] rdata_q;

   assign sel = reg_sel_e'(host_sel_i);

   bufirq_lane_expand #(.NUM_BUF(NUM_BUF), .LANE_W(LANE_W)) u_wen_mask (
      .wr_i (host_wr_i && sel == SEL_MASK),
      .be_i (host_be_i),
      .wen_o(wen_mask)
   );

   bufirq_lane_expand #(.NUM_BUF(NUM_BUF), .LANE_W(LANE_W)) u_wen_flag (
      .wr_i (host_wr_i && sel == SEL_FLAG),
      .be_i (host_be_i),
      .wen_o(wen_flag)
   );

   bufirq_mask_reg #(.NUM_BUF(NUM_BUF)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .wen_i  (wen_mask),
      .wdata_i(host_wdata_i),
      .mask_o (mask_q)
   );

   bufirq_flag_reg #(.NUM_BUF(NUM_BUF)) u_flag (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt_i),
      .wen_i     (wen_flag),
      .sel_flag_i(sel == SEL_FLAG),
      .wdata_i   (host_wdata_i),
      .flag_o    (flag_q)
   );

   bufirq_irq_combine #(.NUM_BUF(NUM_BUF), .REG_REQ(REG_REQ)) u_irq (
      .clk   (clk),
      .rst   (rst),
      .flag_i(flag_q),
      .mask_i(mask_q),
      .vec_o (irq_vec_o),
      .req_o (irq_o)
   );

   // registered read port, no side effects
   always_ff @(posedge clk) begin
      if (rst)            rdata_q <= '0;
      else if (host_rd_i) rdata_q <= (sel == SEL_FLAG) ? flag_q : mask_q;
   end

   assign host_rdata_o = rdata_q;

   // R10: read data holds when no read is strobed
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      !host_rd_i |=> $stable(host_rdata_o));
   // R5: the enable register changes only on an enable write
   a_r5_mask_write_only: assert property (@(posedge clk) disable iff (rst)
      !(host_wr_i && sel == SEL_MASK) |=> $stable(mask_q));
endmodule

// File: tb/bufirq_ctrl_tb_top.sv
module bufirq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] evt_i = '0;
   logic        host_sel_i = 1'b0;
   logic        host_wr_i = 1'b0;
   logic        host_rd_i = 1'b0;
   logic [1:0]  host_be_i = '0;
   logic [15:0] host_wdata_i = '0;
   logic [15:0] host_rdata_o;
   logic [15:0] irq_vec_o;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bufirq_ctrl dut_i (
      .clk(clk), .rst(rst), .evt_i(evt_i),
      .host_sel_i(host_sel_i), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
      .host_be_i(host_be_i), .host_wdata_i(host_wdata_i),
      .host_rdata_o(host_rdata_o), .irq_vec_o(irq_vec_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic sel, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      host_sel_i = sel; host_be_i = be; host_wdata_i = d; host_wr_i = 1'b1;
      @(negedge clk);
      host_wr_i = 1'b0; host_be_i = '0; host_wdata_i = '0;
   endtask

   task automatic host_read(input logic sel, output logic [15:0] d);
      @(negedge clk);
      host_sel_i = sel; host_rd_i = 1'b1;
      @(negedge clk);
      host_rd_i = 1'b0;
      d = host_rdata_o;
   endtask

   task automatic pulse(input logic [15:0] e);
      @(negedge clk);
      evt_i = e;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1 irq_vec after reset", irq_vec_o, 16'h0);
      check("R1 irq after reset", {15'h0, irq_o}, 16'h0);
      host_read(1'b0, d); check("R1 enable reg reset", d, 16'h0);
      host_read(1'b1, d); check("R1 pending reg reset", d, 16'h0);
   endtask

   task automatic t_events();
      logic [15:0] d;
      pulse(16'h8001);
      host_read(1'b1, d); check("R2 events set pending", d, 16'h8001);
      check("R6 masked out with enables 0", irq_vec_o, 16'h0);
   endtask

   task automatic t_mask_rw();
      logic [15:0] d;
      host_write(1'b0, 2'b01, 16'hA5C3);
      host_read(1'b0, d); check("R4 low lane only", d, 16'h00C3);
      host_write(1'b0, 2'b10, 16'h1234);
      host_read(1'b0, d); check("R5 high lane write", d, 16'h12C3);
   endtask

   task automatic t_mask_effect();
      check("R6 vec = pending & enable", irq_vec_o, 16'h0001);
      check("R9 request high", {15'h0, irq_o}, 16'h1);
      host_write(1'b0, 2'b11, 16'h8000);
      check("R7 enable change moves vec", irq_vec_o, 16'h8000);
      host_write(1'b0, 2'b11, 16'h0000);
      check("R7 enable cleared negates vec", irq_vec_o, 16'h0000);
      check("R9 request lags vec by one cycle", {15'h0, irq_o}, 16'h1);
      @(negedge clk);
      check("R9 request low after lag", {15'h0, irq_o}, 16'h0);
   endtask

   task automatic t_w1c();
      logic [15:0] d;
      host_write(1'b1, 2'b11, 16'h0001);
      host_read(1'b1, d); check("R3 write one clears bit 0", d, 16'h8000);
      host_write(1'b1, 2'b11, 16'h0000);
      host_read(1'b1, d); check("R3 write zero no change", d, 16'h8000);
      host_write(1'b1, 2'b01, 16'h8000);
      host_read(1'b1, d); check("R4 disabled lane keeps pending", d, 16'h8000);
      host_write(1'b1, 2'b10, 16'h8000);
      host_read(1'b1, d); check("R3 high lane clear", d, 16'h0000);
   endtask

   task automatic t_collision();
      logic [15:0] d;
      pulse(16'h0008);
      @(negedge clk);
      evt_i = 16'h0008;
      host_sel_i = 1'b1; host_be_i = 2'b11; host_wdata_i = 16'h0008; host_wr_i = 1'b1;
      @(negedge clk);
      evt_i = '0; host_wr_i = 1'b0; host_be_i = '0; host_wdata_i = '0;
      host_read(1'b1, d); check("R8 event beats clear", d, 16'h0008);
      host_write(1'b1, 2'b11, 16'h0008);
      host_read(1'b1, d); check("R3 clear after collision", d, 16'h0000);
   endtask

   task automatic t_read_noclear();
      logic [15:0] d;
      pulse(16'h0020);
      host_read(1'b1, d); check("R10 first read", d, 16'h0020);
      host_read(1'b1, d); check("R10 read has no side effect", d, 16'h0020);
      repeat (3) @(negedge clk);
      check("R10 rdata holds", host_rdata_o, 16'h0020);
   endtask

   task automatic t_mask_no_flag();
      logic [15:0] d;
      host_write(1'b0, 2'b11, 16'hFFFF);
      host_read(1'b1, d); check("R11 enable write keeps pending", d, 16'h0020);
      check("R7 enable set on pending asserts", irq_vec_o, 16'h0020);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_events();
      t_mask_rw();
      t_mask_effect();
      t_w1c();
      t_collision();
      t_read_noclear();
      t_mask_no_flag();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule